// File: doc/BRIEF.md
# I2C Target Register Interface

This block is a target on a two-wire I2C-compatible bus. It gives a host controller read and write access to a small bank of registers. SCL and SDA come in as plain logic levels from the pads. The system clock oversamples them, and the block answers by pulling SDA low through a single open-drain enable. A host writes by sending the target address, then a byte that sets the register pointer, then any number of data bytes. A host reads by setting the pointer, issuing a repeated START with the read address, and clocking bytes out until it answers with NACK.

The register map has two parts. Byte-wide registers sit at the bottom of the address space. Above them sit 16-bit registers, each split across two neighbouring addresses with the low-order byte at the lower address. A 16-bit register changes only once both of its halves have arrived back to back in one write transfer, so a reader never sees a half-updated value. Any address beyond the map reads back as all ones.

Top module: `i2c_regbank_target`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x6B. The address goes MSB first, followed by a direction bit (0 = write, 1 = read). Any other address receives no ACK, and the block stays off the bus until the next START.
- R2: In a write transfer, the first byte after the address loads the 8-bit register pointer. Each later byte is stored at the pointer, and the pointer then steps by one.
- R3: A read transfer starts at the current pointer, which is kept from earlier transfers. The pointer steps by one per byte and wraps from 0xFF to 0x00. The target keeps sending bytes until the host NACKs a byte, and then it leaves SDA released.
- R4: Addresses 0x00 to 0x03 are byte registers. Addresses 0x04 to 0x07 hold two 16-bit registers: 0x04 and 0x06 are the low bytes, and 0x05 and 0x07 are the high bytes. A read of any address from 0x08 to 0xFF returns 0xFF.
- R5: A 16-bit register is updated only when its high byte is written directly after its own low byte, in the same transfer. A low byte on its own, a high byte on its own, or a pair split by a STOP or a repeated START leaves the register unchanged.
- R6: Data bytes written to addresses outside the map are acknowledged and have no effect on any register.
- R7: SDA is only ever pulled low or released. After reset, while the bus is idle, and after a STOP, SDA is released.
- R8: A START, repeated START or STOP is recognised as an SDA edge while SCL is high, at any point in a transfer. A STOP in the middle of a byte discards that byte, and the target answers the next transfer normally.
- R9: After reset, every register reads as 0x00 and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The address is swept over all 128 values, so the one acknowledged address is separated from its near neighbours. The 16-bit registers are tried with several write patterns: both halves in order, a low byte alone, a high byte alone, a pair split by a repeated START, and a burst that runs from a byte register into a word. Together these show that a commit needs both halves in sequence. Reads cover bursts across the edge of the map and the pointer wrap, pointer reuse across separate transfers, unmapped writes, and a STOP in the middle of a byte. Each of these separates correct pointer stepping and the all-ones rule from a stale or misrouted read.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe, sda_pipe;
  logic scl_cur, scl_prv, sda_cur, sda_prv;

  // Released bus reads high, so reset to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_i};
      sda_pipe <= {sda_pipe[PW-2:0], sda_i};
    end
  end

  assign scl_cur = scl_pipe[PW-2];
  assign scl_prv = scl_pipe[PW-1];
  assign sda_cur = sda_pipe[PW-2];
  assign sda_prv = sda_pipe[PW-1];

  assign scl_rise  = scl_cur & ~scl_prv;
  assign scl_fall  = ~scl_cur & scl_prv;
  assign sda_s     = sda_cur;
  // Frame conditions: SDA moves while SCL is held high.
  assign start_det = scl_cur & scl_prv & sda_prv & ~sda_cur;
  assign stop_det  = scl_cur & scl_prv & ~sda_prv & sda_cur;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h6B,
  parameter int         AW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_pull
);
  tgt_state_t state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [6:0] tx;
  logic       rw_read;
  logic       ptr_phase;
  logic       host_nack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      tx        <= '0;
      rw_read   <= 1'b0;
      ptr_phase <= 1'b0;
      host_nack <= 1'b0;
      ptr       <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      sda_pull  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (shreg[7:1] == TGT_ADDR) begin
                rw_read   <= shreg[0];
                ptr_phase <= 1'b1;
                sda_pull  <= 1'b1;
                state     <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_read) begin
                tx       <= rd_data[6:0];
                sda_pull <= ~rd_data[7];
                ptr      <= ptr + 1'b1;
                state    <= ST_RD;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              sda_pull <= 1'b1;
              state    <= ST_WR_ACK;
              if (ptr_phase) begin
                ptr       <= shreg[AW-1:0];
                ptr_phase <= 1'b0;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_pull <= 1'b0;
                state    <= ST_RD_ACK;
              end else begin
                sda_pull <= ~tx[6];
                tx       <= {tx[5:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              host_nack <= sda_s;
            end else if (scl_fall) begin
              if (host_nack) begin
                state <= ST_IDLE;
              end else begin
                tx       <= rd_data[6:0];
                sda_pull <= ~rd_data[7];
                ptr      <= ptr + 1'b1;
                bit_cnt  <= '0;
                state    <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: an ACK phase is only reached from a matching address byte
  a_r1_ack_on_match: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> $past(shreg[7:1]) == TGT_ADDR);
  // R8: a STOP always returns the engine to idle
  a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> state == ST_IDLE);
  // R7: no pull while idle
  a_r7_idle_release: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> !sda_pull);
  // R2: the pointer sits one past each stored byte
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ptr == AW'(wr_addr + 1'b1));
  // R3: each byte sent out advances the pointer
  a_r3_rd_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && $past(state) != ST_RD) |-> ptr == AW'($past(ptr) + 1'b1));
endmodule

// File: rtl/i2c_reg_store.sv
module i2c_reg_store #(
  parameter int BYTE_REGS = 4,
  parameter int WORD_REGS = 2,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          abort,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int WORD_BASE = BYTE_REGS;
  localparam int MAP_END   = BYTE_REGS + 2 * WORD_REGS;
  localparam int BW        = (BYTE_REGS > 1) ? $clog2(BYTE_REGS) : 1;
  localparam int IDXW      = (WORD_REGS > 1) ? $clog2(WORD_REGS) : 1;

  logic [7:0]      byte_q [BYTE_REGS];
  logic [15:0]     word_q [WORD_REGS];
  logic [7:0]      shadow_lo;
  logic [IDXW-1:0] shadow_idx;
  logic            shadow_vld;

  logic            wr_is_byte, wr_is_word, whigh;
  logic [AW-1:0]   woff, roff;
  logic [IDXW-1:0] widx, ridx;

  assign wr_is_byte = wr_addr < AW'(BYTE_REGS);
  assign wr_is_word = (wr_addr >= AW'(WORD_BASE)) && (wr_addr < AW'(MAP_END));
  assign woff       = wr_addr - AW'(WORD_BASE);
  assign whigh      = woff[0];
  assign widx       = IDXW'(woff >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BYTE_REGS; i++) byte_q[i] <= '0;
    end else if (wr_en && wr_is_byte) begin
      byte_q[wr_addr[BW-1:0]] <= wr_data;
    end
  end

  // Low half waits here until its partner arrives.
  always_ff @(posedge clk) begin
    if (rst || abort) begin
      shadow_vld <= 1'b0;
      shadow_lo  <= '0;
      shadow_idx <= '0;
    end else if (wr_en) begin
      if (wr_is_word && !whigh) begin
        shadow_lo  <= wr_data;
        shadow_idx <= widx;
        shadow_vld <= 1'b1;
      end else begin
        shadow_vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORD_REGS; i++) word_q[i] <= '0;
    end else if (wr_en && wr_is_word && whigh && shadow_vld && shadow_idx == widx) begin
      word_q[widx] <= {wr_data, shadow_lo};
    end
  end

  assign roff = rd_addr - AW'(WORD_BASE);
  assign ridx = IDXW'(roff >> 1);

  always_comb begin
    if (rd_addr < AW'(BYTE_REGS))
      rd_data = byte_q[rd_addr[BW-1:0]];
    else if (rd_addr < AW'(MAP_END))
      rd_data = roff[0] ? word_q[ridx][15:8] : word_q[ridx][7:0];
    else
      rd_data = 8'hFF;
  end

  for (genvar g = 0; g < WORD_REGS; g++) begin : g_word_chk
    // R5: a word only moves on a write that found a waiting low half
    a_r5_word_commit: assert property (@(posedge clk) disable iff (rst)
      !$stable(word_q[g]) |-> $past(wr_en && shadow_vld));
  end
  for (genvar g = 0; g < BYTE_REGS; g++) begin : g_byte_chk
    // R6: byte registers move only on a write strobe
    a_r6_byte_quiet: assert property (@(posedge clk) disable iff (rst)
      !$stable(byte_q[g]) |-> $past(wr_en));
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter logic [6:0] TGT_ADDR    = 7'h6B,
  parameter int         BYTE_REGS   = 4,
  parameter int         WORD_REGS   = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int AW = 8;

  logic scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic wr_en;
  logic [AW-1:0] ptr, wr_addr;
  logic [7:0] wr_data, rd_data;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm #(.TGT_ADDR(TGT_ADDR), .AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_pull(sda_pull_o)
  );

  i2c_reg_store #(.BYTE_REGS(BYTE_REGS), .WORD_REGS(WORD_REGS), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .abort(start_det | stop_det), .rd_addr(ptr), .rd_data(rd_data)
  );
endmodule

// File: tb/i2c_regbank_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regbank_target_tb_top;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_o;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  exp_byte [4];
  logic [15:0] exp_word [2];
  logic [7:0]  wbuf [8];
  logic [7:0]  rbuf [8];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_o;

  i2c_regbank_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    logic [15:0] w;
    if (a < 8'd4) return exp_byte[a[1:0]];
    if (a < 8'd8) begin
      w = exp_word[a[1]];
      return a[0] ? w[15:8] : w[7:0];
    end
    return 8'hFF;
  endfunction

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ackd);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl = 1'b1; q();
    ackd = !sda_line;
    q(); scl = 1'b0; q();
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); b[i] = sda_line; q(); scl = 1'b0;
    end
    sda_m = nack; q(); scl = 1'b1; q(); q(); scl = 1'b0;
  endtask

  // R2/R6: pointer byte then n data bytes, every byte must be acknowledged
  task automatic do_write(input logic [7:0] p, input int n, input string req);
    bit a;
    bus_start();
    send_byte(8'hD6, a); chk(a, req, a, 1);
    send_byte(p, a);     chk(a, req, a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); chk(a, req, a, 1);
    end
    bus_stop();
  endtask

  task automatic set_ptr_rd(input logic [7:0] p, input int n);
    bit a;
    bus_start();
    send_byte(8'hD6, a); chk(a, "R1", a, 1);
    send_byte(p, a);     chk(a, "R2", a, 1);
    bus_start();
    send_byte(8'hD7, a); chk(a, "R1", a, 1);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
    bus_stop();
  endtask

  // R3/R4: burst read from p, compared against the model with 8-bit wrap
  task automatic rd_cmp(input logic [7:0] p, input int n, input string req);
    set_ptr_rd(p, n);
    for (int k = 0; k < n; k++)
      chk(rbuf[k] == exp_rd(8'(p + k)), req, rbuf[k], exp_rd(8'(p + k)));
    chk(sda_line === 1'b1, "R3", sda_line, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    for (int i = 0; i < 4; i++) exp_byte[i] = 8'h00;
    for (int i = 0; i < 2; i++) exp_word[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sda_pull_o == 1'b0, "R7 reset release", sda_pull_o, 0);

    // R9: pointer starts at 0, plain read from reset gives reg0..reg7 = 0
    bus_start();
    send_byte(8'hD7, a); chk(a, "R9", a, 1);
    for (int k = 0; k < 8; k++) recv_byte(k == 7, rbuf[k]);
    bus_stop();
    for (int k = 0; k < 8; k++) chk(rbuf[k] == 8'h00, "R9 reset value", rbuf[k], 0);

    // R1: all 128 addresses, write direction
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      send_byte({7'(ad), 1'b0}, a);
      bus_stop();
      chk(a == (ad == 'h6B), "R1 address match", a, ad == 'h6B);
    end
    bus_start(); send_byte(8'hD5, a); bus_stop(); chk(!a, "R1 read dir 0x6A", a, 0);
    bus_start(); send_byte(8'hD9, a); bus_stop(); chk(!a, "R1 read dir 0x6C", a, 0);
    chk(sda_pull_o == 1'b0, "R7 idle after stop", sda_pull_o, 0);

    // R2/R4: byte registers, burst and single
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h0F; wbuf[3] = 8'hF0;
    do_write(8'h00, 4, "R2");
    exp_byte[0] = 8'hA5; exp_byte[1] = 8'h3C; exp_byte[2] = 8'h0F; exp_byte[3] = 8'hF0;
    rd_cmp(8'h00, 4, "R2 byte burst");
    wbuf[0] = 8'h81; do_write(8'h02, 1, "R2"); exp_byte[2] = 8'h81;
    rd_cmp(8'h00, 4, "R2 single write");

    // R3: pointer kept across transfers (write at 1 leaves pointer at 2)
    wbuf[0] = 8'h5A; do_write(8'h01, 1, "R2"); exp_byte[1] = 8'h5A;
    bus_start(); send_byte(8'hD7, a); recv_byte(1'b1, b); bus_stop();
    chk(b == exp_byte[2], "R3 pointer reuse", b, exp_byte[2]);
    bus_start(); send_byte(8'hD7, a); recv_byte(1'b1, b); bus_stop();
    chk(b == exp_byte[3], "R3 pointer step", b, exp_byte[3]);

    // R4/R5: both words, low byte first
    wbuf[0] = 8'h34; wbuf[1] = 8'h12; wbuf[2] = 8'h78; wbuf[3] = 8'h56;
    do_write(8'h04, 4, "R5");
    exp_word[0] = 16'h1234; exp_word[1] = 16'h5678;
    rd_cmp(8'h04, 4, "R4 little endian");

    // R5: low half alone
    wbuf[0] = 8'hEE; do_write(8'h06, 1, "R5");
    rd_cmp(8'h06, 2, "R5 low only");
    // R5: high half alone
    wbuf[0] = 8'h99; do_write(8'h05, 1, "R5");
    rd_cmp(8'h04, 2, "R5 high only");
    // R5/R8: pair split by repeated START
    bus_start();
    send_byte(8'hD6, a); send_byte(8'h04, a); send_byte(8'hAA, a);
    bus_start();
    send_byte(8'hD6, a); chk(a, "R8 restart", a, 1);
    send_byte(8'h05, a); send_byte(8'hBB, a);
    bus_stop();
    rd_cmp(8'h04, 2, "R5 split pair");
    // R2/R5: burst from byte register into a word
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'h03, 3, "R2");
    exp_byte[3] = 8'h11; exp_word[0] = 16'h3322;
    rd_cmp(8'h00, 8, "R5 burst commit");

    // R6: unmapped writes acked and ignored
    wbuf[0] = 8'h77; wbuf[1] = 8'h66;
    do_write(8'h10, 2, "R6 unmapped ack");
    rd_cmp(8'h00, 8, "R6 no effect");
    wbuf[0] = 8'hC3; wbuf[1] = 8'hC4;
    do_write(8'h08, 2, "R6 unmapped ack");
    rd_cmp(8'h00, 8, "R6 no effect");

    // R4: unmapped reads, edge of map, R3 wrap
    for (int ad = 8; ad < 16; ad++) rd_cmp(8'(ad), 1, "R4 unmapped");
    rd_cmp(8'h80, 1, "R4 unmapped");
    rd_cmp(8'h06, 4, "R4 map edge");
    rd_cmp(8'hFE, 3, "R3 wrap");

    // R8: STOP in mid byte discards it
    bus_start();
    send_byte(8'hD6, a); send_byte(8'h00, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    bus_stop();
    chk(sda_pull_o == 1'b0, "R8 release on stop", sda_pull_o, 0);
    rd_cmp(8'h00, 1, "R8 partial byte dropped");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule